// File: doc/BRIEF.md
# Word ECC Read-Modify-Write Engine

This block sits between a byte-oriented requester and a word-wide storage array. Each storage word holds 32 data bits together with 6 check bits of a single-error-correcting Hamming code. A read request returns one byte of the addressed word. If a single bit of the stored 38-bit word has flipped, the byte is returned already corrected.

A write request carries a byte-lane enable mask. When the mask is partial, the engine fetches the stored word, corrects it and replaces only the enabled lanes. It then recomputes the check bits and writes the whole 38-bit word back. A write with every lane enabled skips the fetch. A write with no lane enabled rewrites the corrected word unchanged, which scrubs a flipped bit out of storage.

Requests are handled one at a time behind a ready/valid handshake. The control is a five-state machine:

- `ST_IDLE` accepts a request. It moves to `ST_FETCH` for a read or a partial write, and to `ST_WRITE` for a full write.
- `ST_FETCH` issues a storage read and always moves to `ST_CHECK`.
- `ST_CHECK` decodes the returned word. It moves to `ST_REPLY` for a read and to `ST_WRITE` for a write.
- `ST_REPLY` presents the byte and returns to `ST_IDLE`.
- `ST_WRITE` issues the storage write and returns to `ST_IDLE`.

Top module: `ecc_word_rmw`

## Requirements
- R1: A stored word is `{check[5:0], data[31:0]}`. Data bit j sits at the j-th 1-based codeword position that is not a power of two (positions 3, 5, 6, 7, 9, … 38). Check bit i is the XOR of the data bits whose position has bit i set.
- R2: A read returns byte lane `req_addr[1:0]` (lane k is data bits 8k+7..8k) of word `req_addr[ADDR_W-1:2]`. `rsp_valid` is high for exactly one cycle, starting at the second rising edge after acceptance.
- R3: If exactly one stored data bit is flipped, the read returns the original data.
- R4: If exactly one stored check bit is flipped, the returned data is unaffected.
- R5: `ecc_fixed` pulses for one cycle whenever the decoded syndrome is nonzero. The pulse coincides with `rsp_valid` for a read or with the storage write for a partial write, and `ecc_fixed` is low otherwise.
- R6: A write with a partial lane mask issues one storage read on the first rising edge after acceptance. It then writes back, one edge after the read data returns, the corrected word with the enabled lanes replaced and fresh check bits.
- R7: A write with all four lanes enabled issues no storage read. It writes the encoded new word on the first rising edge after acceptance.
- R8: `req_ready` is low from acceptance until the request's last storage access or response is finished. At most one of `req_ready`, `rsp_valid` and `mem_en` is high in any cycle.
- R9: During and right after reset, `req_ready` is high and `rsp_valid`, `mem_en` and `ecc_fixed` are low.
- R10: A write with an all-zero lane mask writes back the corrected stored word unchanged, with check bits regenerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; low two bits select the lane |
| req_be | input | 4 | Write lane enables |
| req_wdata | input | 32 | Write data, lane-aligned |
| rsp_valid | output | 1 | Read byte valid |
| rsp_rdata | output | 8 | Corrected read byte |
| ecc_fixed | output | 1 | Nonzero syndrome seen (one-cycle pulse) |
| mem_en | output | 1 | Storage access strobe |
| mem_we | output | 1 | Storage write when `mem_en` is high |
| mem_addr | output | ADDR_W-2 | Storage word address |
| mem_wdata | output | 38 | Encoded word to store |
| mem_rdata | input | 38 | Stored word, valid one cycle after a read strobe |

## Verification
A state machine stuck outside `ST_IDLE` shows within one cycle as `req_ready` staying low. A lost branch between `ST_CHECK` and `ST_REPLY`/`ST_WRITE` shows as a missing or extra storage access on the second edge after acceptance. A wrong position map or parity mask shows on the very first write as a mismatched stored word. It also shows on the first injected flip, as a wrong byte or as a missing `ecc_fixed` pulse. Flips are injected into every check bit and into spread data bits, each followed by a read or a partial write, so that correction and merge errors reach the ports in the same request.

// File: rtl/ecc_word_pkg.sv
package ecc_word_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 6;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_REPLY,
        ST_WRITE
    } state_t;

    // 1-based codeword position of data bit j (powers of two are check slots)
    function automatic int data_pos(input int j);
        int seen;
        int pos;
        seen = 0;
        pos  = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == j) pos = p;
                seen++;
            end
        end
        return pos;
    endfunction

    // data bits covered by check bit i
    function automatic data_t cover_mask(input int i);
        data_t m;
        m = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (((data_pos(j) >> i) & 1) == 1) m[j] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ecc_word_enc.sv
module ecc_word_enc
    import ecc_word_pkg::*;
(
    input  data_t data_i,
    output chk_t  chk_o
);
    generate
        for (genvar i = 0; i < CHK_W; i++) begin : g_chk
            localparam data_t MASK = cover_mask(i);
            assign chk_o[i] = ^(data_i & MASK);
        end
    endgenerate
endmodule

// File: rtl/ecc_word_dec.sv
module ecc_word_dec
    import ecc_word_pkg::*;
(
    input  code_t code_i,
    output data_t data_o,
    output logic  fixed_o
);
    chk_t recomputed;
    chk_t syndrome;

    ecc_word_enc u_enc (
        .data_i (code_i[DATA_W-1:0]),
        .chk_o  (recomputed)
    );

    assign syndrome = recomputed ^ code_i[CODE_W-1:DATA_W];
    assign fixed_o  = |syndrome;

    // a syndrome naming a check slot or an unused position flips no data bit
    generate
        for (genvar j = 0; j < DATA_W; j++) begin : g_fix
            localparam int POS = data_pos(j);
            assign data_o[j] = code_i[j] ^ (syndrome == chk_t'(POS));
        end
    endgenerate
endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge
    import ecc_word_pkg::*;
(
    input  data_t            old_i,
    input  data_t            new_i,
    input  logic [LANES-1:0] be_i,
    output data_t            data_o
);
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign data_o[8*k +: 8] = be_i[k] ? new_i[8*k +: 8] : old_i[8*k +: 8];
        end
    endgenerate
endmodule

// File: rtl/ecc_word_rmw.sv
module ecc_word_rmw
    import ecc_word_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES-1:0]        req_be,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic [7:0]              rsp_rdata,
    output logic                    ecc_fixed,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [ADDR_W-LANE_W-1:0] mem_addr,
    output logic [CODE_W-1:0]       mem_wdata,
    input  logic [CODE_W-1:0]       mem_rdata
);
    localparam int WORD_AW = ADDR_W - LANE_W;

    state_t           state_q, state_d;
    logic             write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0] be_q;
    data_t            wdata_q;
    data_t            word_q;
    logic             fixed_q;

    data_t            dec_data;
    logic             dec_fixed;
    data_t            merged;
    chk_t             enc_chk;
    logic             accept;
    logic             full_wr;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign full_wr = req_write && (&req_be);

    ecc_word_dec u_dec (
        .code_i  (mem_rdata),
        .data_o  (dec_data),
        .fixed_o (dec_fixed)
    );

    ecc_lane_merge u_merge (
        .old_i  (dec_data),
        .new_i  (wdata_q),
        .be_i   (be_q),
        .data_o (merged)
    );

    ecc_word_enc u_enc (
        .data_i (word_q),
        .chk_o  (enc_chk)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = full_wr ? ST_WRITE : ST_FETCH;
            ST_FETCH: state_d = ST_CHECK;
            ST_CHECK: state_d = write_q ? ST_WRITE : ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request and word registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            word_q  <= '0;
            fixed_q <= 1'b0;
        end else begin
            fixed_q <= (state_q == ST_CHECK) && dec_fixed;
            if (accept) begin
                write_q <= req_write;
                addr_q  <= req_addr;
                be_q    <= req_be;
                wdata_q <= req_wdata;
                if (full_wr) word_q <= req_wdata;
            end else if (state_q == ST_CHECK) begin
                word_q <= write_q ? merged : dec_data;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_REPLY);
        mem_en    = (state_q == ST_FETCH) || (state_q == ST_WRITE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = addr_q[ADDR_W-1:LANE_W];
        mem_wdata = {enc_chk, word_q};
        rsp_rdata = word_q[{addr_q[LANE_W-1:0], 3'b000} +: 8];
        ecc_fixed = fixed_q;
    end

    logic unused_ok;
    assign unused_ok = ^WORD_AW;
endmodule

// File: rtl/ecc_word_rmw_chk.sv
module ecc_word_rmw_chk
    import ecc_word_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [LANES-1:0] req_be,
    input logic             rsp_valid,
    input logic             ecc_fixed,
    input logic             mem_en,
    input logic             mem_we
);
    AST_FULL_WR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write && (&req_be)) |=> (mem_en && mem_we)); // R7
    AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_write && (&req_be))) |=> (mem_en && !mem_we)); // R6
    AST_FIX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_fixed |=> !ecc_fixed); // R5
    AST_FIX_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_fixed |-> (rsp_valid || (mem_en && mem_we))); // R5
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, mem_en, req_ready})); // R8
    AST_REPLY_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> !rsp_valid && !mem_en); // R2
endmodule

bind ecc_word_rmw ecc_word_rmw_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .ecc_fixed (ecc_fixed),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
);

// File: tb/tb_ecc_word_rmw.sv
module tb_ecc_word_rmw;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int WORDS = 1 << (AW - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0] req_be = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [7:0] rsp_rdata;
    logic ecc_fixed;
    logic mem_en, mem_we;
    logic [AW-3:0] mem_addr;
    logic [37:0] mem_wdata;
    logic [37:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;

    logic [37:0] mem [WORDS];
    logic [31:0] gold [WORDS];
    bit dirty [WORDS];

    typedef struct { logic [7:0] b; logic fx; string tag; } rsp_t;
    typedef struct { logic [AW-3:0] a; logic [37:0] w; logic fx; string tag; } wr_t;
    rsp_t rq[$];
    wr_t  wq[$];

    ecc_word_rmw #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ecc_fixed(ecc_fixed),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R1 encoding computed from codeword positions
    function automatic logic [37:0] enc(input logic [31:0] d);
        logic [38:1] cw;
        logic [5:0] c;
        int j;
        cw = '0;
        j = 0;
        for (int p = 1; p <= 38; p++) if ((p & (p - 1)) != 0) begin cw[p] = d[j]; j++; end
        c = '0;
        for (int i = 0; i < 6; i++)
            for (int p = 1; p <= 38; p++) if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
        return {c, d};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // storage model, one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (rq.size() == 0) check(0, "R2 unexpected response", 64'(rsp_rdata), 0);
                else begin
                    rsp_t e;
                    e = rq.pop_front();
                    check(rsp_rdata == e.b, e.tag, 64'(rsp_rdata), 64'(e.b));
                    check(ecc_fixed == e.fx, {e.tag, " R5 flag"}, 64'(ecc_fixed), 64'(e.fx));
                end
            end else if (mem_en && mem_we) begin
                if (wq.size() == 0) check(0, "R6 unexpected write", 64'(mem_wdata), 0);
                else begin
                    wr_t e;
                    e = wq.pop_front();
                    check(mem_addr == e.a, {e.tag, " addr"}, 64'(mem_addr), 64'(e.a));
                    check(mem_wdata == e.w, e.tag, 64'(mem_wdata), 64'(e.w));
                    check(ecc_fixed == e.fx, {e.tag, " R5 flag"}, 64'(ecc_fixed), 64'(e.fx));
                end
            end else if (ecc_fixed) begin
                check(0, "R5 stray flag", 64'(ecc_fixed), 0);
            end
        end
    end

    task automatic inject(input int w, input int b);
        mem[w][b] = ~mem[w][b];
        dirty[w] = 1'b1;
    endtask

    task automatic do_req(input bit wr, input int baddr, input logic [3:0] be,
                          input logic [31:0] wd, input string tag);
        int w;
        int rd0;
        w = baddr >> 2;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = rd_cnt;
        if (!wr) begin
            rq.push_back('{gold[w][8*(baddr%4) +: 8], dirty[w], tag});
        end else begin
            logic [31:0] nw;
            logic fx;
            nw = gold[w];
            for (int k = 0; k < 4; k++) if (be[k]) nw[8*k +: 8] = wd[8*k +: 8];
            fx = (&be) ? 1'b0 : dirty[w];
            gold[w] = nw;
            dirty[w] = 1'b0;
            wq.push_back('{(AW-2)'(w), enc(nw), fx, tag});
        end
        req_valid = 1'b1; req_write = wr; req_addr = AW'(baddr); req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R8 ready low after accept", 64'(req_ready), 0);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (wr && (&be)) check(rd_cnt == rd0, "R7 no storage read", 64'(rd_cnt - rd0), 0);
        else check(rd_cnt == rd0 + 1, "R6 one storage read", 64'(rd_cnt - rd0), 1);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin mem[i] = enc(32'h0); gold[i] = '0; dirty[i] = 1'b0; end
        mem_rdata = '0;
        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_en && !ecc_fixed, "R9 reset outputs",
              64'({req_ready, rsp_valid, mem_en, ecc_fixed}), 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_en && !ecc_fixed, "R9 after reset",
              64'({req_ready, rsp_valid, mem_en, ecc_fixed}), 64'h8);

        do_req(1, 0, 4'hF, 32'hA5C3_0F96, "R7 R1 full write");
        for (int k = 0; k < 4; k++) do_req(0, k, 4'h0, '0, "R2 clean read lane");

        do_req(1, 5*4, 4'hF, 32'hDEAD_BEEF, "R7 full write w5");
        inject(5, 13);
        do_req(0, 5*4 + 1, 4'h0, '0, "R3 data flip read");
        do_req(1, 5*4 + 1, 4'b0010, 32'h0000_7700, "R6 partial merge");
        do_req(0, 5*4 + 1, 4'h0, '0, "R6 merged readback");

        do_req(1, 7*4, 4'hF, 32'h1234_5678, "R7 full write w7");
        for (int b = 32; b < 38; b++) begin
            inject(7, b);
            do_req(0, 7*4 + (b % 4), 4'h0, '0, "R4 check flip read");
            inject(7, b);
            dirty[7] = 1'b0;
        end

        do_req(1, 20*4, 4'hF, 32'hC001_D00D, "R7 full write w20");
        for (int b = 0; b < 32; b += 5) begin
            inject(20, b);
            do_req(0, 20*4 + b / 8, 4'h0, '0, "R3 data flip sweep");
            inject(20, b);
            dirty[20] = 1'b0;
        end

        do_req(1, 9*4, 4'hF, 32'h0F0F_F0F0, "R7 full write w9");
        inject(9, 0);
        do_req(1, 9*4, 4'h0, 32'hFFFF_FFFF, "R10 zero-mask scrub");
        do_req(0, 9*4 + 3, 4'h0, '0, "R10 scrubbed read");
        do_req(1, 9*4, 4'b1001, 32'hAB00_00CD, "R6 two-lane merge");
        do_req(0, 9*4 + 3, 4'h0, '0, "R6 lane3 readback");

        repeat (4) @(negedge clk);
        check(rq.size() == 0 && wq.size() == 0, "R2 all expected results seen",
              64'(rq.size() + wq.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule